// File: doc/BRIEF.md
# Serial Transmitter with Break and Polarity Control

This block is the transmit half of an asynchronous serial port. Characters written through a data write port go into a small first-in first-out buffer. From there they move one at a time into a shift register, which sends each one as a framed character on a single serial line. A baud tick input sets the bit timing: each bit lasts a fixed number of ticks. A control write port loads several control fields at once: a transmit enable, a two-bit interrupt mode, a break request, a polarity bit and an infrared-mode select.

The block drives two status flags. One shows that the buffer cannot accept another character. The other shows that both the buffer and the shift register are empty; it updates only after a fixed delay following a write. A single interrupt output pulses on the event chosen by the interrupt mode: a character moves into the shift register, a move leaves the buffer empty, or the last frame finishes. A break request sends a long all-zero frame, and hardware clears the request once that frame is done. The idle level of the line can be inverted, and the meaning of the polarity bit flips when infrared mode is selected.

Top module: `serial_tx_core`

## Requirements
- R1: A cycle with `ctl_we` high loads `ctl_en`, `ctl_mode`, `ctl_brk`, `ctl_inv` and `ctl_ir` into the control state, and they take effect from the next cycle.
- R2: A data frame is a start bit (0), then 8 data bits sent least significant bit first, then one stop bit (1). Each bit lasts 16 baud ticks. A frame starts as soon as the shift register is free and a character is waiting in the buffer.
- R3: The buffer holds 4 characters. `sts_full` is 1 exactly when 4 are held. A data write while the buffer is full is dropped, and no frame is ever sent for it.
- R4: While the enable is 0, `tx_line` sits at the port level (1 by default). Clearing the enable aborts the frame in progress and empties the buffer. Data writes while disabled are dropped.
- R5: `sts_empty` is 1 only when both the buffer and the shift register are empty, and it resets to 1. After a data write is accepted on a clock edge, `sts_empty` falls at the second clock edge that follows.
- R6: While the break request is set and the shift register is free, the block sends a break frame: a start bit, twelve 0 bits and a stop bit, that is 13 bit times of low line in a row. A character queued behind the break is sent after the break's stop bit.
- R7: `brk_pend` shows the break request. Hardware clears it when the break frame finishes its stop bit.
- R8: Interrupt mode 00: `irq` pulses in the cycle after each move of a character from the buffer into the shift register.
- R9: Interrupt mode 10: `irq` pulses only after a move that leaves the buffer empty. A write on the same edge keeps the buffer from being empty, so that move does not count.
- R10: Interrupt mode 01: `irq` pulses after a frame ends when nothing is left to send: no character in the buffer and no break request pending.
- R11: Interrupt mode 11 never raises `irq`. In every mode, `irq` is high for a single cycle at a time.
- R12: The line is inverted when `ctl_inv` XOR `ctl_ir` is 1. With infrared mode off, a polarity bit of 1 gives idle 0. With infrared mode on, a polarity bit of 1 gives idle 1. The inversion applies to every bit of a frame alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_en | input | 1 | Transmit enable field |
| ctl_mode | input | 2 | Interrupt mode field |
| ctl_brk | input | 1 | Break request field |
| ctl_inv | input | 1 | Line polarity field |
| ctl_ir | input | 1 | Infrared-mode select field |
| dat_we | input | 1 | Data write strobe |
| dat_wdata | input | 8 | Character to queue |
| baud_tick | input | 1 | Baud tick, one-cycle pulses |
| tx_line | output | 1 | Serial transmit line |
| sts_full | output | 1 | Buffer full flag |
| sts_empty | output | 1 | Buffer and shift register empty flag |
| brk_pend | output | 1 | Break request pending |
| irq | output | 1 | Transmit interrupt pulse |

## Verification
Two functions can fall on the same clock edge. A data write can land on the edge where a waiting character moves into the shift register, and the frame-end event can coincide with a queued character or a pending break. The bench provokes the first case with back-to-back writes in the draining interrupt mode: the move that would empty the buffer is cancelled by the write on that edge, so a three-character burst gives one pulse, not two. It provokes the second with a break requested just before a data write, in the end-of-transmission mode, where only the data frame's end may raise the pulse. A behavioural model, built on a queue, judges every output on every clock.

// File: rtl/serial_tx_pkg.sv
`timescale 1ns/1ps
package serial_tx_pkg;

  typedef enum logic [1:0] {
    IRQ_ON_LOAD  = 2'b00,
    IRQ_ON_IDLE  = 2'b01,
    IRQ_ON_DRAIN = 2'b10,
    IRQ_NONE     = 2'b11
  } irq_mode_e;

  // Line inversion: polarity sense flips when infrared mode is selected.
  function automatic logic line_flip(input logic inv, input logic ir);
    return inv ^ ir;
  endfunction

endpackage

// File: rtl/stx_fifo.sv
`timescale 1ns/1ps
module stx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic                         push,
  input  logic                         pop,
  input  logic [W-1:0]                 din,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt_n;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  assign dout = mem[rp];

  always_comb begin
    cnt_n = count;
    if (push && !pop) cnt_n = count + 1'b1;
    else if (pop && !push) cnt_n = count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
      full  <= 1'b0;
    end else begin
      if (push) wp <= adv(wp);
      if (pop)  rp <= adv(rp);
      count <= cnt_n;
      full  <= (cnt_n == CW'(DEPTH));
    end
  end
endmodule

// File: rtl/stx_shifter.sv
`timescale 1ns/1ps
module stx_shifter #(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16,
  parameter int BRK_ZEROS     = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              tick,
  input  logic              ld_data,
  input  logic              ld_brk,
  input  logic [DATA_W-1:0] din,
  output logic              busy,
  output logic              is_brk,
  output logic              line_bit,
  output logic              done
);
  localparam int FW = ((BRK_ZEROS > DATA_W) ? BRK_ZEROS : DATA_W) + 2;
  localparam int LW = $clog2(FW+1);
  localparam int PW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;

  logic [FW-1:0] sr;
  logic [LW-1:0] left;
  logic [PW-1:0] ph;
  logic          bit_end;

  assign bit_end  = tick && (ph == PW'(TICKS_PER_BIT-1));
  assign done     = busy && bit_end && (left == LW'(1));
  assign line_bit = busy ? sr[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sr     <= '1;
      left   <= '0;
      ph     <= '0;
      busy   <= 1'b0;
      is_brk <= 1'b0;
    end else if (ld_brk) begin
      sr     <= FW'({1'b1, {BRK_ZEROS{1'b0}}, 1'b0});
      left   <= LW'(BRK_ZEROS + 2);
      ph     <= '0;
      busy   <= 1'b1;
      is_brk <= 1'b1;
    end else if (ld_data) begin
      sr     <= FW'({1'b1, din, 1'b0});
      left   <= LW'(DATA_W + 2);
      ph     <= '0;
      busy   <= 1'b1;
      is_brk <= 1'b0;
    end else if (busy && tick) begin
      if (bit_end) begin
        ph   <= '0;
        sr   <= {1'b1, sr[FW-1:1]};
        left <= left - 1'b1;
        if (left == LW'(1)) busy <= 1'b0;
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end
endmodule

// File: rtl/serial_tx_core.sv
`timescale 1ns/1ps
module serial_tx_core
  import serial_tx_pkg::*;
#(
  parameter int   DATA_W        = 8,
  parameter int   FIFO_DEPTH    = 4,
  parameter int   TICKS_PER_BIT = 16,
  parameter int   BRK_ZEROS     = 12,
  parameter logic PORT_LEVEL    = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic              ctl_en,
  input  logic [1:0]        ctl_mode,
  input  logic              ctl_brk,
  input  logic              ctl_inv,
  input  logic              ctl_ir,
  input  logic              dat_we,
  input  logic [DATA_W-1:0] dat_wdata,
  input  logic              baud_tick,
  output logic              tx_line,
  output logic              sts_full,
  output logic              sts_empty,
  output logic              brk_pend,
  output logic              irq
);
  localparam int CNT_W = $clog2(FIFO_DEPTH+1);

  // control state
  logic      en_q, brk_q, inv_q, ir_q;
  irq_mode_e mode_q;

  // datapath links
  logic              push, pop, start_brk;
  logic [DATA_W-1:0] f_dout;
  logic [CNT_W-1:0]  f_count;
  logic              f_full, f_empty;
  logic              sh_busy, sh_is_brk, sh_line, sh_done;

  // interrupt events and status pipeline
  logic ev_load, ev_drain, ev_idle, irq_d;
  logic raw_empty_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      mode_q <= IRQ_ON_LOAD;
      brk_q  <= 1'b0;
      inv_q  <= 1'b0;
      ir_q   <= 1'b0;
    end else if (ctl_we) begin
      en_q   <= ctl_en;
      mode_q <= irq_mode_e'(ctl_mode);
      brk_q  <= ctl_brk;
      inv_q  <= ctl_inv;
      ir_q   <= ctl_ir;
    end else if (sh_done && sh_is_brk) begin
      brk_q  <= 1'b0;
    end
  end

  assign f_empty   = (f_count == '0);
  assign push      = dat_we && en_q && !f_full;
  assign start_brk = en_q && !sh_busy && brk_q;
  assign pop       = en_q && !sh_busy && !brk_q && !f_empty;

  stx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .clr   (!en_q),
    .push  (push),
    .pop   (pop),
    .din   (dat_wdata),
    .dout  (f_dout),
    .count (f_count),
    .full  (f_full)
  );

  stx_shifter #(
    .DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT), .BRK_ZEROS(BRK_ZEROS)
  ) u_shift (
    .clk      (clk),
    .rst      (rst),
    .clr      (!en_q),
    .tick     (baud_tick),
    .ld_data  (pop),
    .ld_brk   (start_brk),
    .din      (f_dout),
    .busy     (sh_busy),
    .is_brk   (sh_is_brk),
    .line_bit (sh_line),
    .done     (sh_done)
  );

  assign ev_load  = pop;
  assign ev_drain = pop && (f_count == CNT_W'(1)) && !push;
  assign ev_idle  = sh_done && f_empty && !push && !(brk_q && !sh_is_brk);

  always_comb begin
    unique case (mode_q)
      IRQ_ON_LOAD:  irq_d = ev_load;
      IRQ_ON_IDLE:  irq_d = ev_idle;
      IRQ_ON_DRAIN: irq_d = ev_drain;
      default:      irq_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq         <= 1'b0;
      raw_empty_q <= 1'b1;
      sts_empty   <= 1'b1;
    end else begin
      irq         <= en_q && irq_d;
      raw_empty_q <= f_empty && !sh_busy;
      sts_empty   <= raw_empty_q;
    end
  end

  assign sts_full = f_full;
  assign brk_pend = brk_q;
  assign tx_line  = en_q ? (sh_line ^ line_flip(inv_q, ir_q)) : PORT_LEVEL;
endmodule

// File: rtl/serial_tx_core_chk.sv
`timescale 1ns/1ps
module serial_tx_core_chk #(
  parameter int FIFO_DEPTH = 4,
  parameter int CNT_W      = $clog2(FIFO_DEPTH+1)
) (
  input logic             clk,
  input logic             rst,
  input logic             en_q,
  input logic [1:0]       mode_q,
  input logic [CNT_W-1:0] count,
  input logic             busy,
  input logic             irq,
  input logic             sts_empty,
  input logic             sts_full
);
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(FIFO_DEPTH));

  a_r3_full_flag: assert property (@(posedge clk) disable iff (rst)
    sts_full |-> (count == CNT_W'(FIFO_DEPTH)));

  a_r5_empty_lag: assert property (@(posedge clk) disable iff (rst)
    (count != '0) |-> ##2 !sts_empty);

  a_r4_abort_clears: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> ((count == '0) && !busy));

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  a_r11_mode3_quiet: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'b11) |=> !irq);
endmodule

bind serial_tx_core serial_tx_core_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en_q      (en_q),
  .mode_q    (mode_q),
  .count     (f_count),
  .busy      (sh_busy),
  .irq       (irq),
  .sts_empty (sts_empty),
  .sts_full  (sts_full)
);

// File: tb/serial_tx_core_tb.sv
`timescale 1ns/1ps
module serial_tx_core_tb;
  localparam int DEPTH = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_we = 0, ctl_en = 0, ctl_brk = 0, ctl_inv = 0, ctl_ir = 0;
  logic [1:0] ctl_mode = 2'b00;
  logic       dat_we = 0;
  logic [7:0] dat_wdata = 8'h00;
  logic       baud_tick = 1'b0;
  logic       tx_line, sts_full, sts_empty, brk_pend, irq;

  int n_chk = 0, n_fail = 0;
  int tick_div = 1, tcyc = 0;
  int irq_cnt = 0, run = 0, maxrun = 0;
  bit model_on = 0;

  always #2.5 clk = ~clk;

  serial_tx_core u_dut (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_en(ctl_en), .ctl_mode(ctl_mode),
    .ctl_brk(ctl_brk), .ctl_inv(ctl_inv), .ctl_ir(ctl_ir), .dat_we(dat_we),
    .dat_wdata(dat_wdata), .baud_tick(baud_tick), .tx_line(tx_line),
    .sts_full(sts_full), .sts_empty(sts_empty), .brk_pend(brk_pend), .irq(irq)
  );

  // ---------------- reference model ----------------
  bit         m_en, m_brk, m_inv, m_ir, m_busy, m_isbrk, m_raw, m_empty, m_irq;
  logic [1:0] m_mode;
  logic [13:0] m_bits;
  int         m_left, m_ph;
  logic [7:0] q[$];

  always @(posedge clk) begin
    int qs;
    bit done, push, sbrk, pop, ev0, ev1, ev2, irq_n, brk_clr;
    if (rst) begin
      m_en = 0; m_brk = 0; m_inv = 0; m_ir = 0; m_mode = 2'b00;
      m_busy = 0; m_isbrk = 0; m_raw = 1; m_empty = 1; m_irq = 0;
      m_bits = '1; m_left = 0; m_ph = 0; q.delete();
    end else begin
      qs      = q.size();
      done    = m_busy && baud_tick && (m_ph == 15) && (m_left == 1);
      brk_clr = done && m_isbrk;
      push    = dat_we && m_en && (qs < DEPTH);
      sbrk    = m_en && !m_busy && m_brk;
      pop     = m_en && !m_busy && !m_brk && (qs > 0);
      ev0     = pop;
      ev2     = pop && (qs == 1) && !push;
      ev1     = done && (qs == 0) && !push && !(m_brk && !m_isbrk);
      case (m_mode)
        2'b00:   irq_n = ev0;
        2'b01:   irq_n = ev1;
        2'b10:   irq_n = ev2;
        default: irq_n = 0;
      endcase
      m_empty = m_raw;
      m_raw   = (qs == 0) && !m_busy;
      m_irq   = m_en && irq_n;
      if (!m_en) begin
        q.delete(); m_busy = 0; m_isbrk = 0; m_ph = 0; m_left = 0; m_bits = '1;
      end else begin
        if (sbrk) begin
          m_bits = 14'b10000000000000; m_left = 14; m_isbrk = 1; m_busy = 1; m_ph = 0;
        end else if (pop) begin
          m_bits = {5'b00001, q[0], 1'b0}; void'(q.pop_front());
          m_left = 10; m_isbrk = 0; m_busy = 1; m_ph = 0;
        end else if (m_busy && baud_tick) begin
          if (m_ph == 15) begin
            m_ph = 0; m_bits = {1'b1, m_bits[13:1]}; m_left--;
            if (m_left == 0) m_busy = 0;
          end else m_ph++;
        end
        if (push) q.push_back(dat_wdata);
      end
      if (ctl_we) begin
        m_en = ctl_en; m_mode = ctl_mode; m_brk = ctl_brk; m_inv = ctl_inv; m_ir = ctl_ir;
      end else if (brk_clr) m_brk = 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison and monitors (away from the active edge)
  always @(negedge clk) begin
    logic exp_tx;
    tcyc++;
    baud_tick = ((tcyc % tick_div) == 0);
    if (irq) irq_cnt++;
    if (tx_line === 1'b0) run++; else run = 0;
    if (run > maxrun) maxrun = run;
    if (!rst && model_on) begin
      exp_tx = !m_en ? 1'b1 : ((m_busy ? m_bits[0] : 1'b1) ^ (m_inv ^ m_ir));
      chk("R2/R12 tx_line", 32'(tx_line), 32'(exp_tx));
      chk("R3 sts_full", 32'(sts_full), 32'(q.size() == DEPTH));
      chk("R5 sts_empty", 32'(sts_empty), 32'(m_empty));
      chk("R7 brk_pend", 32'(brk_pend), 32'(m_brk));
      chk("R8 R9 R10 irq", 32'(irq), 32'(m_irq));
    end
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic ctl(input bit en, input logic [1:0] mode, input bit brk, input bit inv, input bit ir);
    ctl_we = 1; ctl_en = en; ctl_mode = mode; ctl_brk = brk; ctl_inv = inv; ctl_ir = ir;
    @(negedge clk);
    ctl_we = 0;
  endtask

  task automatic burst(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      dat_we = 1; dat_wdata = 8'(base + i);
      @(negedge clk);
    end
    dat_we = 0;
  endtask

  task automatic wait_idle();
    repeat (4) @(negedge clk);
    for (int i = 0; i < 20000 && !sts_empty; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion (all requirements)");
    report();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // reset state
    chk("R4 reset tx_line", 32'(tx_line), 32'd1);
    chk("R5 reset sts_empty", 32'(sts_empty), 32'd1);
    chk("R3 reset sts_full", 32'(sts_full), 32'd0);
    chk("R11 reset irq", 32'(irq), 32'd0);
    chk("R7 reset brk_pend", 32'(brk_pend), 32'd0);
    rst = 0; model_on = 1;
    @(negedge clk);

    // R1 / R12: control fields and idle level
    ctl(1, 2'b00, 0, 1, 0);
    chk("R1 R12 idle inv=1 ir=0", 32'(tx_line), 32'd0);
    ctl(1, 2'b00, 0, 1, 1);
    chk("R12 idle inv=1 ir=1", 32'(tx_line), 32'd1);
    ctl(1, 2'b00, 0, 0, 1);
    chk("R12 idle inv=0 ir=1", 32'(tx_line), 32'd0);
    ctl(1, 2'b00, 0, 0, 0);
    chk("R12 idle inv=0 ir=0", 32'(tx_line), 32'd1);

    // R5: empty flag lag
    burst(1, 8'h3C);
    chk("R5 empty one edge after write", 32'(sts_empty), 32'd1);
    @(negedge clk);
    chk("R5 empty held", 32'(sts_empty), 32'd1);
    @(negedge clk);
    chk("R5 empty falls second edge", 32'(sts_empty), 32'd0);
    wait_idle();
    chk("R5 empty after frame", 32'(sts_empty), 32'd1);

    // R3 / R8: fill, overflow, load interrupts
    irq_cnt = 0;
    burst(6, 8'h10);
    chk("R3 full after burst", 32'(sts_full), 32'd1);
    wait_idle();
    chk("R8 R3 load pulses (6th write dropped)", 32'(irq_cnt), 32'd5);

    // R9: drain mode
    ctl(1, 2'b10, 0, 0, 0);
    irq_cnt = 0;
    burst(3, 8'h40);
    wait_idle();
    chk("R9 drain pulses burst of 3", 32'(irq_cnt), 32'd1);
    irq_cnt = 0;
    burst(1, 8'h55);
    wait_idle();
    chk("R9 drain pulse single", 32'(irq_cnt), 32'd1);

    // R10: end-of-transmission mode
    ctl(1, 2'b01, 0, 0, 0);
    irq_cnt = 0;
    burst(3, 8'h70);
    wait_idle();
    chk("R10 idle pulse", 32'(irq_cnt), 32'd1);

    // R11: reserved mode
    ctl(1, 2'b11, 0, 0, 0);
    irq_cnt = 0;
    burst(2, 8'h01);
    wait_idle();
    chk("R11 no pulses", 32'(irq_cnt), 32'd0);

    // R6 / R7: break then queued data
    irq_cnt = 0;
    ctl(1, 2'b01, 1, 0, 0);
    chk("R7 break requested", 32'(brk_pend), 32'd1);
    maxrun = 0; run = 0;
    burst(1, 8'hFF);
    wait_idle();
    chk("R7 break cleared", 32'(brk_pend), 32'd0);
    chk("R6 low run of break", 32'(maxrun), 32'd208);
    chk("R10 one pulse after break+data", 32'(irq_cnt), 32'd1);

    // R12: inverted frame
    ctl(1, 2'b00, 0, 1, 0);
    burst(1, 8'hC3);
    wait_idle();
    chk("R12 idle after inverted frame", 32'(tx_line), 32'd0);

    // R4: abort and disabled writes, slower ticks
    tick_div = 3;
    ctl(1, 2'b00, 0, 0, 0);
    burst(1, 8'h0F);
    repeat (100) @(negedge clk);
    ctl(0, 2'b00, 0, 0, 0);
    repeat (2) @(negedge clk);
    chk("R4 port level when disabled", 32'(tx_line), 32'd1);
    burst(1, 8'h99);
    repeat (3) @(negedge clk);
    chk("R4 empty after abort", 32'(sts_empty), 32'd1);
    chk("R4 not full after abort", 32'(sts_full), 32'd0);
    ctl(1, 2'b00, 0, 0, 0);
    maxrun = 0; run = 0;
    repeat (400) @(negedge clk);
    chk("R4 no frame from dropped write", 32'(maxrun), 32'd0);

    report();
    $finish;
  end
endmodule